// File: doc/BRIEF.md
# Nibble Accumulator Processor Core

This block is a small single-cycle processor working on 4-bit data. A 16-word program store of 8-bit instructions is fixed at elaboration through a parameter. On every clock edge the core fetches the word at the program counter, decodes it and retires it. Three kinds of instruction exist: register moves, arithmetic and logic operations that use an accumulator, and a group that holds a 4-bit immediate. The immediate group covers load-immediate, an unconditional jump and a jump taken when the carry flag is clear.

Eight 4-bit registers share one 3-bit selector. Code 0 is the accumulator and codes 1 to 4 are scratch registers. Code 5 returns the value on the input pins, and writes to it are dropped. Code 6 is the output latch, which drives the output pins and can also be read back. Code 7 is the program counter. The carry flag is sticky. Only add and increment change it. A designer uses the core as a tiny sequencer by passing a program image and wiring the two 4-bit ports.

Top module: `nib_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter, carry, accumulator, registers 1 to 4 and the output latch to zero. The first instruction after reset is fetched from address 0.
- R2: Top bits 00 encode a move. The destination is bits [5:3] and the source is bits [2:0]. Top bits 10 with bits [5:4] = 10 load bits [3:0] into the accumulator. Reading code 5 returns the input pins, and reading code 6 returns the output latch.
- R3: Top bits 01 with function bits [5:3] = 000 add the selected register (bits [2:0]) to the accumulator. The accumulator keeps the low 4 bits of the sum, and the carry flag takes the fifth bit.
- R4: Functions 001, 010 and 011 write the accumulator with the bitwise OR, AND or XOR, in that order, of the accumulator and the selected register.
- R5: Function 100 writes the selected register with its value plus one, modulo 16, and sets the carry to the carry-out. Function 101 writes the selected register with its complement.
- R6: Function 110 rotates the selected register right by one, so bit 0 moves to bit 3. Function 111 rotates it left by one, so bit 3 moves to bit 0.
- R7: Only add and increment change the carry flag. Every other instruction leaves it unchanged.
- R8: Top bits 10 with bits [5:4] = 01 set the program counter to bits [3:0]. With bits [5:4] = 00, the counter goes to bits [3:0] when the carry is 0 and to the next address otherwise.
- R9: A write to code 5 has no effect. A write to code 7 replaces the normal advance of the program counter, so an increment of code 7 at address 15 continues at address 0.
- R10: Words 1011xxxx and 11xxxxxx only advance the program counter. They leave the output and the carry unchanged.
- R11: The output latch changes only when an instruction writes code 6. With the program "increment code 6, jump to 0", the output counts up by one every two cycles and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 4 | External value read through register code 5 |
| out_port | output | 4 | Output latch, written through register code 6 |

## Verification
The bench runs one program that sends intermediate results to the output latch. It does this once with a carry-producing add and once without, so the conditional jump is seen both taken and not taken. A core that inverted the jump condition would follow the wrong path and show a different output sequence. The same program writes to the input-port code just before an AND with that code. A core that let the write land would then show 0xC instead of 0xD. A rotate in the wrong direction, a complement of the wrong register, or an increment of the counter that fails to wrap would each change the traced values. A third program counts with increment followed by a carry-conditional jump. It stops at 0 only if increment sets the carry when it wraps, and a core that left the carry alone would keep counting.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

    localparam int DATA_W     = 4;
    localparam int PC_W       = 4;
    localparam int INSTR_W    = 8;
    localparam int REG_SEL_W  = 3;
    localparam int IMEM_WORDS = 1 << PC_W;
    localparam int NUM_GPR    = 5;

    localparam logic [REG_SEL_W-1:0] REG_ACC = 3'd0;
    localparam logic [REG_SEL_W-1:0] REG_IN  = 3'd5;
    localparam logic [REG_SEL_W-1:0] REG_OUT = 3'd6;
    localparam logic [REG_SEL_W-1:0] REG_PC  = 3'd7;

    typedef logic [DATA_W-1:0]  nib_t;
    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [REG_SEL_W-1:0] rsel_t;

    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_OR   = 3'b001,
        FN_AND  = 3'b010,
        FN_XOR  = 3'b011,
        FN_INC  = 3'b100,
        FN_NOT  = 3'b101,
        FN_ROTR = 3'b110,
        FN_ROTL = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        WSRC_ALU = 2'd0,
        WSRC_MOV = 2'd1,
        WSRC_IMM = 2'd2
    } wsrc_e;

    typedef struct packed {
        alu_fn_e fn;
        rsel_t   src;
        nib_t    imm;
        logic    wr_en;
        rsel_t   wr_sel;
        wsrc_e   wsrc;
        logic    carry_we;
        logic    jump;
        logic    jump_if_nc;
    } dec_t;

    typedef struct packed {
        nib_t result;
        logic carry;
    } alu_out_t;

    function automatic nib_t rot_right(input nib_t v);
        return {v[0], v[DATA_W-1:1]};
    endfunction

    function automatic nib_t rot_left(input nib_t v);
        return {v[DATA_W-2:0], v[DATA_W-1]};
    endfunction

endpackage

// File: rtl/nib_imem.sv
module nib_imem
    import nib_cpu_pkg::*;
#(
    parameter int DEPTH = IMEM_WORDS,
    parameter logic [DEPTH*INSTR_W-1:0] IMAGE = '0
) (
    input  pc_t    addr,
    output instr_t word
);
    instr_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = IMAGE[i*INSTR_W +: INSTR_W];
    end

    assign word = rom[addr];
endmodule

// File: rtl/nib_decode.sv
module nib_decode
    import nib_cpu_pkg::*;
(
    input  instr_t instr,
    output dec_t   dec
);
    always_comb begin
        dec.fn         = alu_fn_e'(instr[5:3]);
        dec.src        = instr[2:0];
        dec.imm        = instr[3:0];
        dec.wr_en      = 1'b0;
        dec.wr_sel     = REG_ACC;
        dec.wsrc       = WSRC_ALU;
        dec.carry_we   = 1'b0;
        dec.jump       = 1'b0;
        dec.jump_if_nc = 1'b0;
        unique case (instr[7:6])
            2'b00: begin
                dec.wr_en  = 1'b1;
                dec.wr_sel = instr[5:3];
                dec.wsrc   = WSRC_MOV;
            end
            2'b01: begin
                dec.wr_en    = 1'b1;
                dec.wsrc     = WSRC_ALU;
                dec.wr_sel   = instr[5] ? instr[2:0] : REG_ACC;
                dec.carry_we = (instr[5:3] == FN_ADD) || (instr[5:3] == FN_INC);
            end
            2'b10: begin
                unique case (instr[5:4])
                    2'b00: begin
                        dec.jump       = 1'b1;
                        dec.jump_if_nc = 1'b1;
                    end
                    2'b01: dec.jump = 1'b1;
                    2'b10: begin
                        dec.wr_en  = 1'b1;
                        dec.wr_sel = REG_ACC;
                        dec.wsrc   = WSRC_IMM;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_cpu_pkg::*;
(
    input  alu_fn_e  fn,
    input  nib_t     acc,
    input  nib_t     opnd,
    output alu_out_t res
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide      = '0;
        res.carry = 1'b0;
        unique case (fn)
            FN_ADD: begin
                wide       = {1'b0, acc} + {1'b0, opnd};
                res.result = wide[DATA_W-1:0];
                res.carry  = wide[DATA_W];
            end
            FN_OR:   res.result = acc | opnd;
            FN_AND:  res.result = acc & opnd;
            FN_XOR:  res.result = acc ^ opnd;
            FN_INC: begin
                wide       = {1'b0, opnd} + 1'b1;
                res.result = wide[DATA_W-1:0];
                res.carry  = wide[DATA_W];
            end
            FN_NOT:  res.result = ~opnd;
            FN_ROTR: res.result = rot_right(opnd);
            FN_ROTL: res.result = rot_left(opnd);
            default: res.result = opnd;
        endcase
    end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
    import nib_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  rsel_t wr_sel,
    input  nib_t  wr_data,
    input  rsel_t rd_sel,
    input  nib_t  in_port,
    input  pc_t   pc_val,
    output nib_t  rd_data,
    output nib_t  acc,
    output nib_t  out_q
);
    nib_t gpr_q [NUM_GPR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NUM_GPR; g++) gpr_q[g] <= '0;
            out_q <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < NUM_GPR; g++)
                if (wr_sel == rsel_t'(g)) gpr_q[g] <= wr_data;
            if (wr_sel == REG_OUT) out_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == REG_IN)       rd_data = in_port;
        else if (rd_sel == REG_OUT) rd_data = out_q;
        else if (rd_sel == REG_PC)  rd_data = nib_t'(pc_val);
        else
            for (int g = 0; g < NUM_GPR; g++)
                if (rd_sel == rsel_t'(g)) rd_data = gpr_q[g];
    end

    assign acc = gpr_q[REG_ACC];
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
    import nib_cpu_pkg::*;
#(
    parameter logic [IMEM_WORDS*INSTR_W-1:0] PROGRAM = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] in_port,
    output logic [3:0] out_port
);
    pc_t      pc_q, pc_next;
    logic     carry_q;
    instr_t   instr;
    dec_t     dec;
    nib_t     src_val, acc, wr_data;
    alu_out_t alu_res;
    logic     pc_wr, take;

    nib_imem #(.DEPTH(IMEM_WORDS), .IMAGE(PROGRAM)) u_imem (
        .addr (pc_q),
        .word (instr)
    );

    nib_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    nib_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.wr_en),
        .wr_sel  (dec.wr_sel),
        .wr_data (wr_data),
        .rd_sel  (dec.src),
        .in_port (in_port),
        .pc_val  (pc_q),
        .rd_data (src_val),
        .acc     (acc),
        .out_q   (out_port)
    );

    nib_alu u_alu (
        .fn   (dec.fn),
        .acc  (acc),
        .opnd (src_val),
        .res  (alu_res)
    );

    always_comb begin
        unique case (dec.wsrc)
            WSRC_MOV: wr_data = src_val;
            WSRC_IMM: wr_data = dec.imm;
            default:  wr_data = alu_res.result;
        endcase
    end

    assign pc_wr = dec.wr_en && (dec.wr_sel == REG_PC);
    assign take  = dec.jump && (!dec.jump_if_nc || !carry_q);

    always_comb begin
        if (pc_wr)     pc_next = pc_t'(wr_data);
        else if (take) pc_next = pc_t'(dec.imm);
        else           pc_next = pc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            carry_q <= 1'b0;
        end else begin
            pc_q <= pc_next;
            if (dec.carry_we) carry_q <= alu_res.carry;
        end
    end
endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] instr,
    input logic [3:0] pc_q,
    input logic       carry_q,
    input logic [3:0] out_port
);
    logic is_add, is_inc, is_jmp, is_jnc, is_nop, wr_out;

    assign is_add = (instr[7:6] == 2'b01) && (instr[5:3] == 3'b000);
    assign is_inc = (instr[7:6] == 2'b01) && (instr[5:3] == 3'b100);
    assign is_jmp = (instr[7:4] == 4'b1001);
    assign is_jnc = (instr[7:4] == 4'b1000);
    assign is_nop = (instr[7:6] == 2'b11) || (instr[7:4] == 4'b1011);
    assign wr_out = ((instr[7:6] == 2'b00) && (instr[5:3] == 3'b110)) ||
                    ((instr[7:6] == 2'b01) && instr[5] && (instr[2:0] == 3'b110));

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_q == 4'd0 && !carry_q && out_port == 4'd0));

    // R7
    a_r7_carry_sticky: assert property (@(posedge clk) disable iff (rst)
        !(is_add || is_inc) |=> $stable(carry_q));

    // R8
    a_r8_jmp_target: assert property (@(posedge clk) disable iff (rst)
        is_jmp |=> pc_q == $past(instr[3:0]));

    // R8
    a_r8_jnc_taken: assert property (@(posedge clk) disable iff (rst)
        (is_jnc && !carry_q) |=> pc_q == $past(instr[3:0]));

    // R8
    a_r8_jnc_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (is_jnc && carry_q) |=> pc_q == 4'($past(pc_q) + 4'd1));

    // R10
    a_r10_nop_only_steps: assert property (@(posedge clk) disable iff (rst)
        is_nop |=> (pc_q == 4'($past(pc_q) + 4'd1)) && $stable(out_port) && $stable(carry_q));

    // R11
    a_r11_out_needs_write: assert property (@(posedge clk) disable iff (rst)
        !wr_out |=> $stable(out_port));
endmodule

bind nib_cpu nib_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .instr    (instr),
    .pc_q     (pc_q),
    .carry_q  (carry_q),
    .out_port (out_port)
);

// File: tb/nib_cpu_test.sv
module nib_cpu_test;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 40;
    localparam int NVEC = 30;

    // 0:MVI 9  1:MOV R1,R5  2:ADD R1  3:MOV R6,R0  4:JNC 7  5:ROTR R6  6:nop(1011)
    // 7:XOR R5 8:MOV R6,R0  9:ROTL R6 10:NOT R6 11:MOV R5,R6 12:AND R5 13:OR R6
    // 14:MOV R6,R0 15:INC R7
    localparam logic [127:0] PROG_MAIN = {
        8'h67, 8'h30, 8'h4E, 8'h55, 8'h2E, 8'h6E, 8'h7E, 8'h30,
        8'h5D, 8'hB3, 8'h76, 8'h87, 8'h30, 8'h41, 8'h0D, 8'hA9};
    // 0:INC R6 1:JMP 0, rest no-ops
    localparam logic [127:0] PROG_CNT = {{14{8'hF0}}, 8'h90, 8'h66};
    // 0:INC R6 1:JNC 0 2:JMP 2
    localparam logic [127:0] PROG_STOP = {{13{8'hF0}}, 8'h92, 8'h80, 8'h66};

    // {in_port, expected out_port after the cycle}
    localparam logic [7:0] VEC [NVEC] = '{
        8'h00, 8'h80, 8'h00, 8'h01,   // R2 MVI/MOV, R3 9+8 -> 1 carry
        8'h01, 8'h08, 8'h08,          // R8 carry set: fall through; R6 rotr 1 -> 8; R10 nop
        8'h88, 8'h09, 8'h03, 8'h0C,   // R4 xor, R6 rotl 9 -> 3, R5 not -> C
        8'h0C, 8'hFC, 8'h0C,          // R9 write to R5 ignored, R4 and/or
        8'h0D, 8'h0D,                 // R9 INC R7 at 15 wraps to 0
        8'h0D, 8'h3D, 8'h0D, 8'h0C,   // pass 2: 9+3 = C, no carry
        8'h0C,                        // R8 jump taken to 7
        8'h5C, 8'h09, 8'h03, 8'h0C,
        8'h0C, 8'h3C, 8'h0C, 8'h0D, 8'h0D};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_port = 4'd0;
    logic [3:0] out_main, out_cnt, out_stop;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_cpu #(.PROGRAM(PROG_MAIN)) uut (
        .clk(clk), .rst(rst), .in_port(in_port), .out_port(out_main));
    nib_cpu #(.PROGRAM(PROG_CNT)) uut_cnt (
        .clk(clk), .rst(rst), .in_port(4'd0), .out_port(out_cnt));
    nib_cpu #(.PROGRAM(PROG_STOP)) uut_stop (
        .clk(clk), .rst(rst), .in_port(4'd0), .out_port(out_stop));

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] v);
        in_port = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_main, 4'd0, "R1 reset main");
        check(out_cnt,  4'd0, "R1 reset cnt");
        check(out_stop, 4'd0, "R1 reset stop");
        rst = 1'b0;

        for (int c = 1; c <= RUN_CYCLES; c++) begin
            logic [3:0] vin, vexp;
            vin  = (c <= NVEC) ? VEC[c-1][7:4] : 4'd0;
            vexp = (c <= NVEC) ? VEC[c-1][3:0] : 4'd0;
            step(vin);
            if (c <= NVEC)
                check(out_main, vexp, $sformatf("R2 R3 R4 R5 R6 R7 R8 R9 R10 trace cycle %0d", c));
            check(out_cnt, 4'((c + 1) / 2), $sformatf("R11 counter cycle %0d", c));
            check(out_stop, (c <= 30) ? 4'((c + 1) / 2) : 4'd0,
                  $sformatf("R5 R7 increment carry stop cycle %0d", c));
        end

        // Reset in mid-run, then the program restarts from address 0
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_main, 4'd0, "R1 mid-run reset main");
        check(out_cnt,  4'd0, "R1 mid-run reset cnt");
        rst = 1'b0;
        step(4'd0);
        step(4'd8);
        step(4'd0);
        check(out_main, 4'd0, "R1 restart before first output write");
        step(4'd0);
        check(out_main, 4'd1, "R1 restart from address 0");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule